// File: doc/BRIEF.md
# Serial Port Status Flag Unit

This block holds the eight status flags of a serial transmit/receive port and implements their read-then-access clearing handshake. The transmit and receive shifters signal events to it as single-cycle pulses. The bus side supplies strobes for a status read, a status write, a data register read and a data register write. The block drives the flag vector continuously. During a status read it also drives the same byte as read data.

A flag is cleared only by a two-step sequence. First a status read must find the flag set, which arms that flag alone. Then a later access to the data register clears it: a write for the two transmit flags, a read for the receive and error flags. Any number of unrelated cycles may fall between the two steps.

An idle-line detector counts consecutive high receiver samples on bit-time strobes. Once it has reported idle and that report has been cleared, it stays silent until a new received frame reopens it.

Top module: `uart_status_flags`

## Requirements
- R1: After reset the flag byte reads 0xC0. The bit positions are 7 tx_empty, 6 tx_done, 5 rx_full, 4 line_idle, 3 overrun, 2 noise, 1 framing, 0 parity.
- R2: A status write changes no flag. It also does not arm a flag, so a following data write leaves the transmit flags set.
- R3: tx_empty (bit 7) sets one cycle after `tx_load_i`. It clears on a data write that follows a status read which saw it set.
- R4: tx_done (bit 6) sets on any cycle in which tx_empty is 1 and `tx_busy_i` is 0. It clears through the same armed data-write handshake as tx_empty.
- R5: `tx_queue_i` clears tx_done. When a set condition and a clear fall in the same cycle, tx_done ends at 0.
- R6: rx_full (bit 5) sets one cycle after `rx_xfer_i`. It clears on a data read that follows a status read which saw it set. A data write does not clear it.
- R7: Overrun, noise, framing and parity (bits 3..0) each set from their own event pulse. Each clears through the armed data-read handshake, and a data write does not clear them.
- R8: Cycles with no bus access between the status read and the data access do not break the handshake.
- R9: Each flag arms on its own. A flag that sets after the status read survives the following data access.
- R10: line_idle (bit 4) sets on the 10th consecutive high sample when `nine_bit_i`=0, and on the 11th when `nine_bit_i`=1. A sample is counted only when `rx_tick_i` is high.
- R11: A low sample on a tick restarts the idle count from zero.
- R12: Until the first `rx_xfer_i`, line_idle cannot set. After line_idle has been cleared by the handshake, it cannot set again until a new `rx_xfer_i`.
- R13: `stat_rdata_o` equals the flag byte while `stat_rd_i` is high and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stat_rd_i | input | 1 | Status register read strobe |
| stat_wr_i | input | 1 | Status register write strobe (ignored) |
| data_rd_i | input | 1 | Low data register read strobe |
| data_wr_i | input | 1 | Low data register write strobe |
| tx_load_i | input | 1 | Transmit shifter took a byte from the data register |
| tx_queue_i | input | 1 | Data, preamble or break character queued |
| tx_busy_i | input | 1 | A character is being shifted out |
| rx_xfer_i | input | 1 | Receive shifter moved a frame into the data register |
| rx_ovr_i | input | 1 | Overrun event |
| rx_noise_i | input | 1 | Noise event |
| rx_frm_i | input | 1 | Framing error event |
| rx_par_i | input | 1 | Parity error event |
| rx_tick_i | input | 1 | Receiver bit-time strobe |
| rx_bit_i | input | 1 | Sampled receiver line level |
| nine_bit_i | input | 1 | 9-bit frame mode select |
| flags_o | output | 8 | Flag vector |
| stat_rdata_o | output | 8 | Status read data |

## Verification
Two collisions are forced on purpose. In the first, tx_done meets its set condition (tx_empty high, shifter not busy) in the same cycle that `tx_queue_i` pulses; the bench expects 0x80 for that cycle and 0xC0 on the next. In the second, overrun sets after rx_full has been armed by a status read, and the data read that follows must clear only rx_full (0xE8 to 0xC8). The idle counter is also driven across a low sample and a change of frame mode, and the expected cycle of the idle flag is predicted from the tick count.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int unsigned NUM_FLAGS = 8;
  localparam int unsigned F_TXE  = 7;
  localparam int unsigned F_TXC  = 6;
  localparam int unsigned F_RXF  = 5;
  localparam int unsigned F_IDLE = 4;
  localparam int unsigned F_OVR  = 3;
  localparam int unsigned F_NOI  = 2;
  localparam int unsigned F_FRM  = 1;
  localparam int unsigned F_PAR  = 0;

  function automatic logic is_tx_flag(input int unsigned idx);
    return (idx == F_TXE) || (idx == F_TXC);
  endfunction
endpackage

// File: rtl/stat_flag_cell.sv
module stat_flag_cell #(
  parameter bit RST_VAL    = 1'b0,
  parameter bit CLEAR_WINS = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic frc_clr_i,
  input  logic stat_rd_i,
  input  logic acc_i,
  output logic flag_o,
  output logic hs_clr_o
);
  logic flag_q, arm_q, hs_clr, clr, flag_d;

  assign hs_clr = arm_q & acc_i & flag_q;
  assign clr    = hs_clr | frc_clr_i;

  always_comb begin
    if (CLEAR_WINS) flag_d = clr ? 1'b0 : (set_i ? 1'b1 : flag_q);
    else            flag_d = set_i ? 1'b1 : (clr ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      // arm only if the flag was seen set by this status read
      if (stat_rd_i)   arm_q <= flag_q;
      else if (acc_i)  arm_q <= 1'b0;
    end
  end

  assign flag_o   = flag_q;
  assign hs_clr_o = hs_clr;

  p_clr_after_arm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> ($past(arm_q) && $past(acc_i)) || $past(frc_clr_i));

  generate
    if (CLEAR_WINS) begin : g_cw
      p_clear_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frc_clr_i |=> !flag_q);
    end else begin : g_sw
      p_set_event_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> flag_q);
    end
  endgenerate
endmodule

// File: rtl/idle_line_det.sv
module idle_line_det #(
  parameter int unsigned IDLE_LEN_8 = 10,
  parameter int unsigned IDLE_LEN_9 = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic bit_i,
  input  logic nine_bit_i,
  input  logic frame_i,
  input  logic idle_clr_i,
  output logic idle_set_o
);
  localparam int unsigned CW = $clog2(IDLE_LEN_9 + 1);

  logic [CW-1:0] cnt_q, thr;
  logic          gate_q;

  assign thr = nine_bit_i ? CW'(IDLE_LEN_9) : CW'(IDLE_LEN_8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      if (tick_i) begin
        if (!bit_i)          cnt_q <= '0;
        else if (cnt_q < thr) cnt_q <= cnt_q + 1'b1;
      end
      if (frame_i)         gate_q <= 1'b1;
      else if (idle_clr_i) gate_q <= 1'b0;
    end
  end

  assign idle_set_o = tick_i & bit_i & gate_q & (CW'(cnt_q + 1'b1) == thr);

  p_low_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !bit_i) |=> cnt_q == '0);
  p_gate_opens_on_frame_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_q) |-> $past(frame_i));
  p_cnt_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(IDLE_LEN_9));
endmodule

// File: rtl/uart_status_flags.sv
module uart_status_flags
  import uart_stat_pkg::*;
#(
  parameter int unsigned IDLE_LEN_8 = 10,
  parameter int unsigned IDLE_LEN_9 = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stat_rd_i,
  input  logic       stat_wr_i,
  input  logic       data_rd_i,
  input  logic       data_wr_i,
  input  logic       tx_load_i,
  input  logic       tx_queue_i,
  input  logic       tx_busy_i,
  input  logic       rx_xfer_i,
  input  logic       rx_ovr_i,
  input  logic       rx_noise_i,
  input  logic       rx_frm_i,
  input  logic       rx_par_i,
  input  logic       rx_tick_i,
  input  logic       rx_bit_i,
  input  logic       nine_bit_i,
  output logic [7:0] flags_o,
  output logic [7:0] stat_rdata_o
);
  logic [NUM_FLAGS-1:0] flags, set_v, frc_v, acc_v, hs_clr_v;
  logic                 idle_set;

  always_comb begin
    set_v         = '0;
    frc_v         = '0;
    set_v[F_TXE]  = tx_load_i;
    set_v[F_TXC]  = flags[F_TXE] & ~tx_busy_i;
    frc_v[F_TXC]  = tx_queue_i;
    set_v[F_RXF]  = rx_xfer_i;
    set_v[F_IDLE] = idle_set;
    set_v[F_OVR]  = rx_ovr_i;
    set_v[F_NOI]  = rx_noise_i;
    set_v[F_FRM]  = rx_frm_i;
    set_v[F_PAR]  = rx_par_i;
  end

  // stat_wr_i is accepted and deliberately unused: status writes are void
  logic unused_wr;
  assign unused_wr = stat_wr_i;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    assign acc_v[i] = is_tx_flag(i) ? data_wr_i : data_rd_i;
    stat_flag_cell #(
      .RST_VAL   (is_tx_flag(i)),
      .CLEAR_WINS(i == F_TXC)
    ) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (set_v[i]),
      .frc_clr_i(frc_v[i]),
      .stat_rd_i(stat_rd_i),
      .acc_i    (acc_v[i]),
      .flag_o   (flags[i]),
      .hs_clr_o (hs_clr_v[i])
    );
  end

  idle_line_det #(
    .IDLE_LEN_8(IDLE_LEN_8),
    .IDLE_LEN_9(IDLE_LEN_9)
  ) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (rx_tick_i),
    .bit_i     (rx_bit_i),
    .nine_bit_i(nine_bit_i),
    .frame_i   (rx_xfer_i),
    .idle_clr_i(hs_clr_v[F_IDLE]),
    .idle_set_o(idle_set)
  );

  assign flags_o      = flags;
  assign stat_rdata_o = stat_rd_i ? flags : 8'h00;

  p_txc_needs_txe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[F_TXC]) |-> $past(flags[F_TXE]) && !$past(tx_busy_i));
  p_rx_no_wr_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && !data_rd_i && flags[F_RXF]) |=> flags[F_RXF]);
  p_idle_rise_on_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[F_IDLE]) |-> $past(rx_tick_i) && $past(rx_bit_i));
endmodule

// File: tb/uart_status_flags_tb_top.sv
module uart_status_flags_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stat_rd = 0, stat_wr = 0, data_rd = 0, data_wr = 0;
  logic tx_load = 0, tx_queue = 0, tx_busy = 0, rx_xfer = 0;
  logic rx_ovr = 0, rx_noise = 0, rx_frm = 0, rx_par = 0;
  logic rx_tick = 0, rx_bit = 1, nine_bit = 0;
  logic [7:0] flags, rdata;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  uart_status_flags dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .stat_rd_i(stat_rd), .stat_wr_i(stat_wr),
    .data_rd_i(data_rd), .data_wr_i(data_wr),
    .tx_load_i(tx_load), .tx_queue_i(tx_queue), .tx_busy_i(tx_busy),
    .rx_xfer_i(rx_xfer), .rx_ovr_i(rx_ovr), .rx_noise_i(rx_noise),
    .rx_frm_i(rx_frm), .rx_par_i(rx_par),
    .rx_tick_i(rx_tick), .rx_bit_i(rx_bit), .nine_bit_i(nine_bit),
    .flags_o(flags), .stat_rdata_o(rdata)
  );

  // driver: one cycle with the strobes set by the caller, expecting exp after the edge
  task automatic cyc(input logic [7:0] exp, input string tag);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk);
    @(negedge clk);
    {stat_rd, stat_wr, data_rd, data_wr, tx_load, tx_queue, rx_xfer} = '0;
    {rx_ovr, rx_noise, rx_frm, rx_par, rx_tick} = '0;
  endtask

  task automatic chk_rdata(input logic [7:0] exp, input string tag);
    #1;
    n_cmp++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s stat_rdata actual=%02h expected=%02h", tag, rdata, exp);
    end
  endtask

  task automatic ticks(input int n, input logic b, input logic [7:0] exp, input string tag);
    for (int k = 0; k < n; k++) begin
      rx_tick = 1'b1;
      rx_bit  = b;
      cyc(exp, tag);
    end
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_cmp++;
        if (flags !== it.exp) begin
          n_bad++;
          $display("FAIL %s flags actual=%02h expected=%02h", it.tag, flags, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(8'hC0, "R1 reset");
    chk_rdata(8'h00, "R13 no read");

    stat_wr = 1; cyc(8'hC0, "R2 status write");
    data_wr = 1; cyc(8'hC0, "R2 write not armed");

    stat_rd = 1; chk_rdata(8'hC0, "R13 read data"); cyc(8'hC0, "R3 arm");
    data_wr = 1; cyc(8'h00, "R3 R4 armed write clears");
    tx_busy = 1; tx_queue = 1; cyc(8'h00, "R4 queued busy");
    tx_load = 1; cyc(8'h80, "R3 load sets empty");
    cyc(8'h80, "R4 busy holds done low");
    tx_busy = 0; cyc(8'hC0, "R4 done sets");
    tx_queue = 1; cyc(8'h80, "R5 clear wins");
    cyc(8'hC0, "R5 done resets");

    rx_xfer = 1; cyc(8'hE0, "R6 rx full");
    stat_rd = 1; cyc(8'hE0, "R9 arm rx full");
    rx_ovr = 1; cyc(8'hE8, "R9 late overrun");
    cyc(8'hE8, "R8 gap cycle");
    data_rd = 1; cyc(8'hC8, "R9 only armed flag clears");
    stat_rd = 1; cyc(8'hC8, "R7 arm overrun");
    data_rd = 1; cyc(8'hC0, "R7 overrun clears");

    rx_noise = 1; rx_frm = 1; rx_par = 1; cyc(8'hC7, "R7 errors set");
    tx_busy = 1;
    stat_rd = 1; chk_rdata(8'hC7, "R13 read errors"); cyc(8'hC7, "R7 arm errors");
    data_wr = 1; cyc(8'h07, "R7 write leaves rx flags");
    data_rd = 1; cyc(8'h00, "R7 read clears errors");

    ticks(5, 1'b1, 8'h00, "R11 partial run");
    ticks(1, 1'b0, 8'h00, "R11 low sample");
    ticks(9, 1'b1, 8'h00, "R10 below ten");
    ticks(1, 1'b1, 8'h10, "R10 tenth high");
    cyc(8'h10, "R10 hold");
    stat_rd = 1; cyc(8'h10, "R10 arm idle");
    data_rd = 1; cyc(8'h00, "R10 idle clears");
    ticks(1, 1'b0, 8'h00, "R12 low");
    ticks(12, 1'b1, 8'h00, "R12 gated");

    rx_xfer = 1; cyc(8'h20, "R12 frame");
    stat_rd = 1; cyc(8'h20, "R6 arm");
    data_rd = 1; cyc(8'h00, "R6 read clears");
    nine_bit = 1;
    ticks(1, 1'b0, 8'h00, "R11 low");
    ticks(10, 1'b1, 8'h00, "R10 nine-bit below");
    ticks(1, 1'b1, 8'h10, "R10 eleventh high");
    cyc(8'h10, "R10 hold nine");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    @(posedge clk);
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule